// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This unit keeps a 64-bit up-counting time base and a 32-bit down-counting decrementer. Both advance only on cycles where the tick-enable input is high, so one slow enable strobe sets the rate for both. A small register port reads and writes the two halves of the time base and the decrementer. A decrementer interrupt is held pending until the interrupt acknowledge path clears it.

The decrementer raises its interrupt in two cases. The first is expiry: on a tick, the count steps from zero to all ones, and it reloads that way by itself. The second is a software write that loads a value with the top bit set while the old count had the top bit clear. A mode input selects a real-time-clock variant. In that variant the lower time-base word is written and read through the mask 0x3FFFFF80, and the upper word behaves as usual. Such a clock is normally driven by a tick of about 7.8125 MHz.

The pending bit is held by a two-state machine. In state PEND_IDLE nothing is pending. Transition IDLE->RAISED is taken on any raise event. In state PEND_RAISED the interrupt is pending. Transition RAISED->IDLE is taken on a clear strobe with no raise event in the same cycle. A raise event with or without a clear keeps or moves the machine to PEND_RAISED.

Top module: `tbdec_unit`

## Requirements
- R1: After reset the time base reads 0 in both words, the decrementer reads 0xFFFFFFFF, and `irq_pending` is 0. The initial load raises no interrupt.
- R2: Each cycle with `tick` high and no write increments the 64-bit time base by one, with carry from the lower word into the upper word.
- R3: A write with `reg_sel`=1 replaces only time-base bits 63:32. A write with `reg_sel`=0 replaces only bits 31:0. The other word keeps its value.
- R4: Each cycle with `tick` high and no decrementer write decrements the decrementer by one. A read with `reg_sel`=2 returns the current count.
- R5: A tick while the count is 0x00000000 loads 0xFFFFFFFF and sets `irq_pending` in the next cycle.
- R6: A decrementer write sets `irq_pending` if and only if bit 31 of the new value is 1 and bit 31 of the old count is 0.
- R7: With `rtc_mode` high, lower-word writes store `wdata & 0x3FFFFF80` and lower-word reads return the stored word ANDed with 0x3FFFFF80. The upper word is unaffected. With `rtc_mode` low, reads return the full stored word.
- R8: A register write in the same cycle as a tick takes priority. The written register takes the written value and does not count in that cycle. The other counter still counts.
- R9: `irq_clr` clears `irq_pending` in the next cycle, unless a raise event occurs in the same cycle, in which case the bit stays set.
- R10: `reg_sel`=3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for time base and decrementer |
| rtc_mode | input | 1 | Selects the masked real-time-clock lower word |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | 0 TB lower, 1 TB upper, 2 decrementer, 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_clr | input | 1 | Acknowledge strobe clearing the pending bit |
| irq_pending | output | 1 | Decrementer interrupt pending |

## Verification
The bench builds the unit with its default parameters: 32-bit words, real-time-clock masking included, and mask 0x3FFFFF80. With a 32-bit decrementer, the expiry wrap is reached within a handful of ticks once a small value is written. The carry into the upper word is reached by writing 0xFFFFFFFF to the lower word and ticking once. The mask boundary is reached by ticking 127 times past the stored value 0x3FFFFF81, so that masked bits roll into bit 30.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;

    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PEND_IDLE   = 1'b0,
        PEND_RAISED = 1'b1
    } pend_state_e;

endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
    parameter int          WORD_W   = 32,
    parameter bit          RTC_EN   = 1'b1,
    parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rtc_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] lo_view,
    output logic [WORD_W-1:0] hi_view
);
    localparam int TB_W = 2 * WORD_W;

    logic [TB_W-1:0]   tb_q;
    logic [WORD_W-1:0] lo_mask;

    generate
        if (RTC_EN) begin : g_rtc
            assign lo_mask = rtc_mode ? RTC_MASK[WORD_W-1:0] : '1;
        end else begin : g_plain
            assign lo_mask = '1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else if (wr_lo) begin
            tb_q[WORD_W-1:0] <= wdata & lo_mask;
        end else if (wr_hi) begin
            tb_q[TB_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            tb_q <= tb_q + 1'b1;
        end
    end

    assign lo_view = tb_q[WORD_W-1:0] & lo_mask;
    assign hi_view = tb_q[TB_W-1:WORD_W];

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi) |=> (tb_q == $past(tb_q) + 1'b1)); // R2
    AST_HI_WRITE_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> (tb_q[WORD_W-1:0] == $past(tb_q[WORD_W-1:0]))); // R3
    AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (tb_q[TB_W-1:WORD_W] == $past(tb_q[TB_W-1:WORD_W]))); // R3

endmodule

// File: rtl/tbdec_decr.sv
module tbdec_decr #(
    parameter int DEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [DEC_W-1:0] wdata,
    output logic [DEC_W-1:0] count,
    output logic             raise
);
    localparam int MSB = DEC_W - 1;

    logic [DEC_W-1:0] cnt_q;
    logic             expire;
    logic             sign_flip;

    assign expire    = tick && !wr && (cnt_q == '0);
    assign sign_flip = wr && wdata[MSB] && !cnt_q[MSB];
    assign raise     = expire || sign_flip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (wr) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;

    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && cnt_q == '0) |=> (cnt_q == '1)); // R5
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_q == $past(wdata))); // R8

endmodule

// File: rtl/tbdec_pend_fsm.sv
module tbdec_pend_fsm
    import tbdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic pending
);
    pend_state_e state_q;
    pend_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE:   if (raise)        state_d = PEND_RAISED;
            PEND_RAISED: if (clr && !raise) state_d = PEND_IDLE;
            default:     state_d = PEND_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PEND_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == PEND_RAISED);
    end

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> pending); // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !raise) |=> !pending); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise && !pending) |=> !pending); // R6

endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
    import tbdec_pkg::*;
#(
    parameter int          WORD_W   = 32,
    parameter bit          RTC_EN   = 1'b1,
    parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rtc_mode,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              irq_clr,
    output logic              irq_pending
);
    reg_sel_e          sel;
    logic              wr_lo, wr_hi, wr_dec;
    logic [WORD_W-1:0] tb_lo, tb_hi, dec_cnt;
    logic              dec_raise;

    assign sel    = reg_sel_e'(reg_sel);
    assign wr_lo  = reg_wr && (sel == SEL_TB_LO);
    assign wr_hi  = reg_wr && (sel == SEL_TB_HI);
    assign wr_dec = reg_wr && (sel == SEL_DEC);

    tbdec_timebase #(
        .WORD_W   (WORD_W),
        .RTC_EN   (RTC_EN),
        .RTC_MASK (RTC_MASK)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rtc_mode (rtc_mode),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .wdata    (reg_wdata),
        .lo_view  (tb_lo),
        .hi_view  (tb_hi)
    );

    tbdec_decr #(
        .DEC_W (WORD_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (wr_dec),
        .wdata (reg_wdata),
        .count (dec_cnt),
        .raise (dec_raise)
    );

    tbdec_pend_fsm u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise   (dec_raise),
        .clr     (irq_clr),
        .pending (irq_pending)
    );

    always_comb begin
        unique case (sel)
            SEL_TB_LO: reg_rdata = tb_lo;
            SEL_TB_HI: reg_rdata = tb_hi;
            SEL_DEC:   reg_rdata = dec_cnt;
            default:   reg_rdata = '0;
        endcase
    end

    AST_SIGN_FLIP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dec && reg_wdata[WORD_W-1] && !dec_cnt[WORD_W-1]) |=> irq_pending); // R6
    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (reg_rdata == '0)); // R10

endmodule

// File: tb/tbdec_unit_tb_top.sv
module tbdec_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    localparam logic [2:0] K_RD  = 3'd0;
    localparam logic [2:0] K_IRQ = 3'd1;
    localparam logic [2:0] K_WR  = 3'd2;
    localparam logic [2:0] K_TK  = 3'd3;
    localparam logic [2:0] K_CLR = 3'd4;
    localparam logic [2:0] K_RTC = 3'd5;
    localparam logic [2:0] K_WT  = 3'd6;
    localparam logic [2:0] K_TC  = 3'd7;

    localparam int NV = 58;
    // {kind, requirement, sel, data, expected}
    localparam logic [72:0] VEC [NV] = '{
        {K_RD,  4'd1,  2'd2, 32'h0,        32'hFFFF_FFFF}, // R1
        {K_IRQ, 4'd1,  2'd0, 32'h0,        32'h0},         // R1
        {K_RD,  4'd1,  2'd0, 32'h0,        32'h0},         // R1
        {K_RD,  4'd1,  2'd1, 32'h0,        32'h0},         // R1
        {K_WR,  4'd6,  2'd2, 32'h3,        32'h0},         // R6
        {K_IRQ, 4'd6,  2'd0, 32'h0,        32'h0},         // R6 positive over negative
        {K_TK,  4'd4,  2'd0, 32'd3,        32'h0},         // R4
        {K_RD,  4'd4,  2'd2, 32'h0,        32'h0},         // R4
        {K_RD,  4'd2,  2'd0, 32'h0,        32'h3},         // R2
        {K_IRQ, 4'd5,  2'd0, 32'h0,        32'h0},         // R5 not yet expired
        {K_TK,  4'd5,  2'd0, 32'd1,        32'h0},         // R5
        {K_IRQ, 4'd5,  2'd0, 32'h0,        32'h1},         // R5
        {K_RD,  4'd5,  2'd2, 32'h0,        32'hFFFF_FFFF}, // R5
        {K_CLR, 4'd9,  2'd0, 32'h0,        32'h0},         // R9
        {K_IRQ, 4'd9,  2'd0, 32'h0,        32'h0},         // R9
        {K_WR,  4'd3,  2'd1, 32'h1,        32'h0},         // R3
        {K_RD,  4'd3,  2'd0, 32'h0,        32'h4},         // R3
        {K_RD,  4'd3,  2'd1, 32'h0,        32'h1},         // R3
        {K_WR,  4'd3,  2'd0, 32'hFFFF_FFFF, 32'h0},        // R3
        {K_RD,  4'd3,  2'd1, 32'h0,        32'h1},         // R3
        {K_TK,  4'd2,  2'd0, 32'd1,        32'h0},         // R2 carry
        {K_RD,  4'd2,  2'd1, 32'h0,        32'h2},         // R2
        {K_RD,  4'd2,  2'd0, 32'h0,        32'h0},         // R2
        {K_WR,  4'd6,  2'd2, 32'h10,       32'h0},         // R6
        {K_IRQ, 4'd6,  2'd0, 32'h0,        32'h0},         // R6
        {K_WR,  4'd6,  2'd2, 32'h8000_0000, 32'h0},        // R6
        {K_IRQ, 4'd6,  2'd0, 32'h0,        32'h1},         // R6
        {K_CLR, 4'd9,  2'd0, 32'h0,        32'h0},         // R9
        {K_WR,  4'd6,  2'd2, 32'h8000_0005, 32'h0},        // R6 negative over negative
        {K_IRQ, 4'd6,  2'd0, 32'h0,        32'h0},         // R6
        {K_WR,  4'd10, 2'd3, 32'h1234_5678, 32'h0},        // R10
        {K_RD,  4'd10, 2'd2, 32'h0,        32'h8000_0005}, // R10
        {K_RD,  4'd10, 2'd3, 32'h0,        32'h0},         // R10
        {K_RD,  4'd10, 2'd0, 32'h0,        32'h0},         // R10
        {K_RD,  4'd10, 2'd1, 32'h0,        32'h2},         // R10
        {K_WT,  4'd8,  2'd2, 32'h7,        32'h0},         // R8
        {K_RD,  4'd8,  2'd2, 32'h0,        32'h7},         // R8
        {K_RD,  4'd8,  2'd0, 32'h0,        32'h1},         // R8 other counter ticks
        {K_WT,  4'd8,  2'd0, 32'h100,      32'h0},         // R8
        {K_RD,  4'd8,  2'd0, 32'h0,        32'h100},       // R8
        {K_RD,  4'd4,  2'd2, 32'h0,        32'h6},         // R4
        {K_RTC, 4'd7,  2'd0, 32'h1,        32'h0},         // R7
        {K_WR,  4'd7,  2'd0, 32'hFFFF_FFFF, 32'h0},        // R7
        {K_RD,  4'd7,  2'd0, 32'h0,        32'h3FFF_FF80}, // R7
        {K_TK,  4'd7,  2'd0, 32'd1,        32'h0},         // R7
        {K_RD,  4'd7,  2'd0, 32'h0,        32'h3FFF_FF80}, // R7
        {K_TK,  4'd7,  2'd0, 32'd127,      32'h0},         // R7
        {K_RD,  4'd7,  2'd0, 32'h0,        32'h0},         // R7
        {K_RD,  4'd7,  2'd1, 32'h0,        32'h2},         // R7
        {K_RTC, 4'd7,  2'd0, 32'h0,        32'h0},         // R7
        {K_RD,  4'd7,  2'd0, 32'h0,        32'h4000_0000}, // R7
        {K_IRQ, 4'd5,  2'd0, 32'h0,        32'h1},         // R5 wrap during ticks
        {K_RD,  4'd4,  2'd2, 32'h0,        32'hFFFF_FF86}, // R4
        {K_CLR, 4'd9,  2'd0, 32'h0,        32'h0},         // R9
        {K_WR,  4'd6,  2'd2, 32'h0,        32'h0},         // R6
        {K_TC,  4'd9,  2'd0, 32'h0,        32'h0},         // R9 set beats clear
        {K_IRQ, 4'd9,  2'd0, 32'h0,        32'h1},         // R9
        {K_RD,  4'd5,  2'd2, 32'h0,        32'hFFFF_FFFF}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rtc_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_clr = 1'b0;
    logic        irq_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbdec_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rtc_mode    (rtc_mode),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq_clr     (irq_clr),
        .irq_pending (irq_pending)
    );

    task automatic step();
        @(posedge clk);
        #1;
        tick    = 1'b0;
        reg_wr  = 1'b0;
        irq_clr = 1'b0;
    endtask

    task automatic check(input logic [3:0] req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  kind;
            logic [3:0]  req;
            logic [1:0]  sel;
            logic [31:0] data;
            logic [31:0] exp;
            {kind, req, sel, data, exp} = VEC[i];
            unique case (kind)
                K_RD:  begin reg_sel = sel; #1 check(req, reg_rdata, exp); end
                K_IRQ: check(req, {31'd0, irq_pending}, exp);
                K_WR:  begin reg_sel = sel; reg_wdata = data; reg_wr = 1'b1; step(); end
                K_TK:  for (int n = 0; n < int'(data); n++) begin tick = 1'b1; step(); end
                K_CLR: begin irq_clr = 1'b1; step(); end
                K_RTC: rtc_mode = data[0];
                K_WT:  begin reg_sel = sel; reg_wdata = data; reg_wr = 1'b1; tick = 1'b1; step(); end
                K_TC:  begin tick = 1'b1; irq_clr = 1'b1; step(); end
                default: ;
            endcase
        end
        // R1: a second reset restores the initial state with nothing pending
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        check(4'd1, {31'd0, irq_pending}, 32'h0);
        reg_sel = 2'd2;
        #1 check(4'd1, reg_rdata, 32'hFFFF_FFFF);
        reg_sel = 2'd1;
        #1 check(4'd1, reg_rdata, 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule